// File: doc/BRIEF.md
# UART Interrupt Prioritization Logic

This block gathers the five interrupt causes of a 16550-style serial port, masks each one with its own enable bit and reports the most urgent unmasked cause as a six-bit identification code. It also drives an active-low interrupt request line. The surrounding port logic supplies event pulses and levels: receive error flags, receive and transmit FIFO occupancy with their trigger thresholds, a baud tick, modem-line change bits and read strobes for the receive holding, line status and modem status registers. It supplies the enable vector as well.

Some causes are sticky and some follow a level. The four receive error flags and the two modem change bits are held until the matching register read clears them. The receive-data and transmit-space causes are recomputed every cycle from the FIFO levels. Their meaning depends on whether FIFO mode is on. A character-timeout detector counts baud ticks while data sits unread in the receive FIFO.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, and whenever no enabled cause is pending, `iir_o` is 6'b000001 and `irq_no` is 1.
- R2: A pulse on any bit of `rx_err_i` latches a line-status cause. When that cause is enabled (`ier_i[2]`) it reports code 6'b000110. The bit order of `rx_err_i` is [0] overrun, [1] framing, [2] parity, [3] break.
- R3: A latched overrun clears only on `rd_lsr_i` and is unaffected by `rd_rhr_i`. Latched framing, parity and break clear only on `rd_rhr_i` and are unaffected by `rd_lsr_i`.
- R4: The timeout cause (code 6'b001100, enable `ier_i[4]`) becomes pending after TICKS_PER_CHAR*TIMEOUT_CHARS baud ticks while `rx_level_i` is nonzero, provided no `rx_char_i` and no `rd_rhr_i` arrives in that time. A tick count one short of the limit does not raise it. `rd_rhr_i`, `rx_char_i` or an empty receive FIFO clears it.
- R5: The receive-data cause (code 6'b000100, enable `ier_i[0]`) is pending when `rx_level_i >= rx_trig_i` with `fifo_en_i`=1, and when `rx_level_i != 0` with `fifo_en_i`=0.
- R6: The transmit cause (code 6'b000010, enable `ier_i[1]`) is pending when `tx_level_i < tx_trig_i` with `fifo_en_i`=1, and when `tx_level_i == 0` with `fifo_en_i`=0.
- R7: A pulse on either bit of `msr_delta_i` latches a modem cause (code 6'b000000, enable `ier_i[3]`). `rd_msr_i` clears it.
- R8: Among enabled pending causes the reported code follows the order line status, timeout, receive data, transmit, modem. As higher causes clear, the next one appears.
- R9: A disabled cause keeps its latched state but changes neither `iir_o` nor `irq_no`. Setting its enable bit makes it visible.
- R10: `iir_o` and `irq_no` are registered and follow the pending state one clock edge later. `irq_no` is 0 exactly when `iir_o[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode select |
| ier_i | input | 5 | Enables: [0] rx data, [1] tx, [2] line status, [3] modem, [4] timeout |
| rx_char_i | input | 1 | Pulse: a character entered the receive FIFO |
| rx_err_i | input | 4 | Error pulses: [0] overrun, [1] framing, [2] parity, [3] break |
| rx_level_i | input | LVL_W | Receive FIFO occupancy |
| rx_trig_i | input | LVL_W | Receive trigger threshold |
| tx_level_i | input | LVL_W | Transmit FIFO occupancy |
| tx_trig_i | input | LVL_W | Transmit trigger threshold |
| baud_tick_i | input | 1 | Baud timing tick |
| msr_delta_i | input | 2 | Modem line change pulses |
| rd_rhr_i | input | 1 | Receive holding register read strobe |
| rd_lsr_i | input | 1 | Line status register read strobe |
| rd_msr_i | input | 1 | Modem status register read strobe |
| iir_o | output | 6 | Identification code |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench sets TICKS_PER_CHAR=2 and TIMEOUT_CHARS=4, which gives an eight-tick timeout window. With that window the bench can check the exact boundary, seven ticks quiet and eight ticks pending, and it can drive all five causes into the pending state at once within a few dozen cycles. LVL_W stays at 5, and the trigger thresholds are set so that both level comparisons are tested at their equality points.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 5;
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;
  localparam int SRC_LS = 2;
  localparam int SRC_MS = 3;
  localparam int SRC_TO = 4;

  localparam int NERR   = 4;
  localparam int ERR_OE = 0;

  typedef logic [5:0] iid_t;
  localparam iid_t IID_NONE = 6'b000001;
  localparam iid_t IID_LS   = 6'b000110;
  localparam iid_t IID_TO   = 6'b001100;
  localparam iid_t IID_RX   = 6'b000100;
  localparam iid_t IID_TX   = 6'b000010;
  localparam iid_t IID_MS   = 6'b000000;
endpackage

// File: rtl/uart_irq_line.sv
module uart_irq_line
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NERR-1:0] err_set_i,
  input  logic            rd_rhr_i,
  input  logic            rd_lsr_i,
  output logic [NERR-1:0] err_q_o
);
  for (genvar i = 0; i < NERR; i++) begin : g_bit
    logic bit_q;
    logic clr;
    // overrun is cleared by the status read, the rest by the data read
    if (i == ERR_OE) begin : g_lsr
      assign clr = rd_lsr_i;
    end else begin : g_rhr
      assign clr = rd_rhr_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           bit_q <= 1'b0;
      else if (err_set_i[i]) bit_q <= 1'b1;
      else if (clr)          bit_q <= 1'b0;
    end
    assign err_q_o[i] = bit_q;
  end
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int TICKS_PER_CHAR = 160,
  parameter int TIMEOUT_CHARS  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  input  logic data_i,
  output logic stale_o
);
  localparam int LIMIT = TICKS_PER_CHAR * TIMEOUT_CHARS;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  // saturates at LIMIT; stale while saturated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i || !data_i) cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT_C) cnt_q <= cnt_q + 1'b1;
  end

  assign stale_o = (cnt_q == LIMIT_C);
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  output iid_t            iir_o,
  output logic            irq_no
);
  logic [NSRC-1:0] act;
  iid_t            iid_d;
  iid_t            iid_q;
  logic            irq_nq;

  assign act = pend_i & en_i;

  always_comb begin
    if      (act[SRC_LS]) iid_d = IID_LS;
    else if (act[SRC_TO]) iid_d = IID_TO;
    else if (act[SRC_RX]) iid_d = IID_RX;
    else if (act[SRC_TX]) iid_d = IID_TX;
    else if (act[SRC_MS]) iid_d = IID_MS;
    else                  iid_d = IID_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iid_q  <= IID_NONE;
      irq_nq <= 1'b1;
    end else begin
      iid_q  <= iid_d;
      irq_nq <= ~|act;
    end
  end

  assign iir_o  = iid_q;
  assign irq_no = irq_nq;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int LVL_W          = 5,
  parameter int TICKS_PER_CHAR = 160,
  parameter int TIMEOUT_CHARS  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [NSRC-1:0]  ier_i,
  input  logic             rx_char_i,
  input  logic [NERR-1:0]  rx_err_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] tx_trig_i,
  input  logic             baud_tick_i,
  input  logic [1:0]       msr_delta_i,
  input  logic             rd_rhr_i,
  input  logic             rd_lsr_i,
  input  logic             rd_msr_i,
  output logic [5:0]       iir_o,
  output logic             irq_no
);
  logic [NERR-1:0] err_q;
  logic [1:0]      msr_q;
  logic            stale;
  logic            rx_data;
  logic            tx_space;
  logic [NSRC-1:0] raw_pend;

  uart_irq_line u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_set_i (rx_err_i),
    .rd_rhr_i  (rd_rhr_i),
    .rd_lsr_i  (rd_lsr_i),
    .err_q_o   (err_q)
  );

  uart_irq_timeout #(
    .TICKS_PER_CHAR (TICKS_PER_CHAR),
    .TIMEOUT_CHARS  (TIMEOUT_CHARS)
  ) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (baud_tick_i),
    .restart_i (rx_char_i | rd_rhr_i),
    .data_i    (|rx_level_i),
    .stale_o   (stale)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msr_q <= '0;
    else         msr_q <= msr_delta_i | (rd_msr_i ? 2'b00 : msr_q);
  end

  assign rx_data  = fifo_en_i ? (rx_level_i >= rx_trig_i) : (rx_level_i != '0);
  assign tx_space = fifo_en_i ? (tx_level_i <  tx_trig_i) : (tx_level_i == '0);

  always_comb begin
    raw_pend         = '0;
    raw_pend[SRC_RX] = rx_data;
    raw_pend[SRC_TX] = tx_space;
    raw_pend[SRC_LS] = |err_q;
    raw_pend[SRC_MS] = |msr_q;
    raw_pend[SRC_TO] = stale;
  end

  uart_irq_arb u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (raw_pend),
    .en_i   (ier_i),
    .iir_o  (iir_o),
    .irq_no (irq_no)
  );
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSRC-1:0]  ier_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic [NERR-1:0]  rx_err_i,
  input logic             rd_rhr_i,
  input logic             rd_lsr_i,
  input logic [NERR-1:0]  err_q_i,
  input logic [NSRC-1:0]  pend_i,
  input logic [5:0]       iir_o,
  input logic             irq_no
);
  // R2
  ls_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[SRC_LS] && ier_i[SRC_LS]) |=> (iir_o == IID_LS && !irq_no));

  // R3
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q_i[ERR_OE] && !rd_lsr_i) |=> err_q_i[ERR_OE]);

  // R3
  fe_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rhr_i && !rx_err_i[1]) |=> !err_q_i[1]);

  // R4
  to_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_i == '0) |=> !pend_i[SRC_TO]);

  // R9
  masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ier_i) == '0) |=> (irq_no && iir_o == IID_NONE));

  // R10
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ier_i) != '0) |=> !irq_no);
endmodule

bind uart_irq_prio uart_irq_prio_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ier_i      (ier_i),
  .rx_level_i (rx_level_i),
  .rx_err_i   (rx_err_i),
  .rd_rhr_i   (rd_rhr_i),
  .rd_lsr_i   (rd_lsr_i),
  .err_q_i    (err_q),
  .pend_i     (raw_pend),
  .iir_o      (iir_o),
  .irq_no     (irq_no)
);

// File: tb/uart_irq_prio_test.sv
module uart_irq_prio_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LVL_W = 5;
  localparam int TPC   = 2;
  localparam int TOC   = 4;

  localparam logic [5:0] C_NONE = 6'b000001;
  localparam logic [5:0] C_LS   = 6'b000110;
  localparam logic [5:0] C_TO   = 6'b001100;
  localparam logic [5:0] C_RX   = 6'b000100;
  localparam logic [5:0] C_TX   = 6'b000010;
  localparam logic [5:0] C_MS   = 6'b000000;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             fifo_en = 1'b1;
  logic [4:0]       ier = 5'b11111;
  logic             rx_char = 1'b0;
  logic [3:0]       rx_err = '0;
  logic [LVL_W-1:0] rx_level = '0;
  logic [LVL_W-1:0] rx_trig = 5'd4;
  logic [LVL_W-1:0] tx_level = 5'd8;
  logic [LVL_W-1:0] tx_trig = 5'd4;
  logic             tick = 1'b0;
  logic [1:0]       msr_delta = '0;
  logic             rd_rhr = 1'b0;
  logic             rd_lsr = 1'b0;
  logic             rd_msr = 1'b0;
  logic [5:0]       iir;
  logic             irq_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  uart_irq_prio #(
    .LVL_W(LVL_W), .TICKS_PER_CHAR(TPC), .TIMEOUT_CHARS(TOC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .ier_i(ier),
    .rx_char_i(rx_char), .rx_err_i(rx_err), .rx_level_i(rx_level),
    .rx_trig_i(rx_trig), .tx_level_i(tx_level), .tx_trig_i(tx_trig),
    .baud_tick_i(tick), .msr_delta_i(msr_delta), .rd_rhr_i(rd_rhr),
    .rd_lsr_i(rd_lsr), .rd_msr_i(rd_msr), .iir_o(iir), .irq_no(irq_n)
  );

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] exp_iir);
    logic exp_irq;
    exp_irq = exp_iir[0];
    n_chk++;
    if (iir !== exp_iir || irq_n !== exp_irq) begin
      n_fail++;
      $display("FAIL %s: iir=%b irq_n=%b expected iir=%b irq_n=%b",
               req, iir, irq_n, exp_iir, exp_irq);
    end
  endtask

  task automatic p_err(input logic [3:0] v);
    rx_err = v; clk_n(1); rx_err = '0; clk_n(2);
  endtask
  task automatic p_rhr();
    rd_rhr = 1'b1; clk_n(1); rd_rhr = 1'b0; clk_n(2);
  endtask
  task automatic p_lsr();
    rd_lsr = 1'b1; clk_n(1); rd_lsr = 1'b0; clk_n(2);
  endtask
  task automatic p_msr();
    rd_msr = 1'b1; clk_n(1); rd_msr = 1'b0; clk_n(2);
  endtask
  task automatic p_delta(input logic [1:0] v);
    msr_delta = v; clk_n(1); msr_delta = '0; clk_n(2);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; clk_n(1); tick = 1'b0; clk_n(1);
    end
    clk_n(1);
  endtask

  task automatic t_reset();
    clk_n(1);
    chk("R1 during reset", C_NONE);
    rst_ni = 1'b1;
    clk_n(3);
    chk("R1 idle after reset", C_NONE);
  endtask

  task automatic t_tx();
    tx_level = 5'd3; clk_n(1);
    chk("R6 fifo below trigger, R10 one edge", C_TX);
    tx_level = 5'd4; clk_n(1);
    chk("R6 at trigger, R10 release next cycle", C_NONE);
    fifo_en = 1'b0; tx_level = 5'd0; clk_n(2);
    chk("R6 holding reg empty", C_TX);
    tx_level = 5'd1; clk_n(2);
    chk("R6 holding reg full", C_NONE);
    fifo_en = 1'b1; tx_level = 5'd8; clk_n(2);
  endtask

  task automatic t_rx();
    rx_level = 5'd4; clk_n(2);
    chk("R5 fifo at trigger", C_RX);
    rx_level = 5'd3; clk_n(2);
    chk("R5 fifo below trigger", C_NONE);
    fifo_en = 1'b0; rx_level = 5'd1; clk_n(2);
    chk("R5 data ready", C_RX);
    rx_level = 5'd0; clk_n(2);
    chk("R5 no data", C_NONE);
    fifo_en = 1'b1; clk_n(2);
  endtask

  task automatic t_line();
    p_err(4'b0010);
    chk("R2 framing error", C_LS);
    p_lsr();
    chk("R3 framing kept on status read", C_LS);
    p_rhr();
    chk("R3 framing cleared on data read", C_NONE);
    p_err(4'b0001);
    chk("R2 overrun", C_LS);
    p_rhr();
    chk("R3 overrun kept on data read", C_LS);
    p_lsr();
    chk("R3 overrun cleared on status read", C_NONE);
    p_err(4'b1100);
    chk("R2 parity and break", C_LS);
    p_rhr();
    chk("R3 parity and break cleared", C_NONE);
  endtask

  task automatic t_timeout();
    rx_level = 5'd1; clk_n(2);
    ticks(TPC * TOC - 1);
    chk("R4 one tick short", C_NONE);
    ticks(1);
    chk("R4 at limit", C_TO);
    p_rhr();
    chk("R4 cleared by data read", C_NONE);
    ticks(TPC * TOC);
    chk("R4 raised again", C_TO);
    rx_char = 1'b1; clk_n(1); rx_char = 1'b0; clk_n(2);
    chk("R4 cleared by new char", C_NONE);
    rx_level = 5'd0; clk_n(2);
  endtask

  task automatic t_modem();
    p_delta(2'b10);
    chk("R7 modem change", C_MS);
    p_msr();
    chk("R7 cleared by status read", C_NONE);
  endtask

  task automatic t_priority();
    rx_level = 5'd5; clk_n(2);
    chk("R8 rx data alone", C_RX);
    ticks(TPC * TOC);
    chk("R8 timeout over rx data", C_TO);
    p_delta(2'b01);
    tx_level = 5'd0;
    p_err(4'b0001);
    chk("R8 line status over all", C_LS);
    p_lsr();
    chk("R8 timeout next", C_TO);
    p_rhr();
    chk("R8 rx data next", C_RX);
    rx_level = 5'd0; clk_n(2);
    chk("R8 tx next", C_TX);
    tx_level = 5'd8; clk_n(2);
    chk("R8 modem last", C_MS);
    p_msr();
    chk("R8 all cleared", C_NONE);
  endtask

  task automatic t_mask();
    ier = 5'b10111;
    p_delta(2'b01);
    chk("R9 modem masked", C_NONE);
    ier = 5'b11111; clk_n(2);
    chk("R9 modem shown on enable", C_MS);
    p_msr();
    ier = 5'b11011;
    p_err(4'b0100);
    chk("R9 line status masked", C_NONE);
    ier = 5'b11111; clk_n(2);
    chk("R9 line status shown on enable", C_LS);
    p_rhr();
    chk("R9 line status cleared", C_NONE);
  endtask

  initial begin
    t_reset();
    t_tx();
    t_rx();
    t_line();
    t_timeout();
    t_modem();
    t_priority();
    t_mask();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clk_n(100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule